// File: doc/BRIEF.md
# Write-Protected Byte Memory with Asynchronous-Style Control

This block is a clocked model of a byte-wide static memory that is controlled by three active-low strobes: chip select, write strobe and output enable. All strobes are sampled on a fast system clock. The block turns those samples into read and write cycles. It stores bytes in an internal array and produces the output-enable flag for an external tri-state data bus. The bus is split here into an input byte, an output byte and a drive flag.

A write window exists while chip select and the write strobe are both low at a clock edge. It opens when the second of the two goes low and closes when the first of the two returns high. The byte is committed when the window closes. After each committed write there is a recovery interval of a set number of clocks, during which the write strobe must stay high before another cycle is accepted.

A protect input, normally driven by a power supervisor, makes every strobe a don't-care. While it is high, the bus outputs are released at once and any write that is still open is dropped.

Top module: `nvbyte_sram`

## Requirements
- R1: With no recovery pending, if cs_n and oe_n are low and we_n is high at a clock edge, then after that edge data_oe is 1 and data_out holds the addressed byte.
- R2: The array holds DEPTH bytes, and the low $clog2(DEPTH) bits of addr select one of them. The upper address bits are ignored, so addresses that differ only above that field reach the same byte.
- R3: A write window opens at the first clock edge at which cs_n and we_n are both sampled low. The order in which the two fell does not matter.
- R4: A write is committed at the first clock edge at which cs_n or we_n is sampled high after the window was open. The byte stored is data_in, and the address used is addr, both taken as they were at the last edge at which the window was open.
- R5: A clock edge that samples we_n low leaves data_oe at 0 after that edge, even while cs_n and oe_n are low.
- R6: While wp is 1, data_oe and data_out are 0 in that same cycle, and no write window opens.
- R7: If wp is sampled high while a window is open, the write is aborted and the target byte keeps its old value. This also holds when wp rises at the same edge at which the window closes.
- R8: After a committed write, REC_CLKS further edges with we_n high must pass before a read or write is accepted. An edge that samples we_n low during that interval restarts the count.
- R9: During and right after reset, data_oe and data_out are 0 and no write is pending.
- R10: data_out is 0 whenever data_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp | input | 1 | Write protect from the power supervisor, active high |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data to the bus |
| data_oe | output | 1 | Bus drive enable for data_out |

## Verification
Two events can fall on the same clock edge: the closing edge of a write window and the rise of the protect input. The bench provokes this by raising wp and we_n together while a window is open. It then clears wp and reads the target byte, which must still hold its old value. A second collision is a read request at the same edge as a commit. The bench releases we_n with cs_n and oe_n still low, and checks that the bus is not driven until the recovery count has run out.

// File: rtl/nvbyte_sram.sv
module nvbyte_sram #(
  parameter int ADDR_W   = 19,
  parameter int DEPTH    = 256,
  parameter int REC_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data_in,
  output logic [7:0]        data_out,
  output logic              data_oe
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int REC_W = $clog2(REC_CLKS + 1);

  logic [7:0]       mem [DEPTH];
  logic             wr_act;
  logic [IDX_W-1:0] hold_idx;
  logic [7:0]       hold_data;
  logic [REC_W-1:0] rec;
  logic             oe_q;
  logic [7:0]       dout_q;

  wire [IDX_W-1:0] idx      = addr[IDX_W-1:0];
  wire             rec_done = (rec == '0);
  wire             win_open = !wp && !cs_n && !we_n && (wr_act || rec_done);
  wire             commit   = wr_act && !win_open && !wp;
  wire             rd_ok    = !wp && !cs_n && !oe_n && we_n && !wr_act && rec_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_act    <= 1'b0;
      hold_idx  <= '0;
      hold_data <= '0;
      rec       <= '0;
      oe_q      <= 1'b0;
      dout_q    <= '0;
    end else begin
      wr_act <= win_open;
      if (win_open) begin
        hold_idx  <= idx;
        hold_data <= data_in;
      end
      if (wp)
        rec <= '0;
      else if (commit)
        rec <= REC_W'(REC_CLKS);
      else if (!rec_done)
        rec <= we_n ? rec - REC_W'(1) : REC_W'(REC_CLKS);
      oe_q   <= rd_ok;
      dout_q <= rd_ok ? mem[idx] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && commit)
      mem[hold_idx] <= hold_data;
  end

  assign data_oe  = oe_q && !wp;
  assign data_out = data_oe ? dout_q : '0;

endmodule

// File: rtl/nvbyte_sram_chk.sv
module nvbyte_sram_chk #(
  parameter int REC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wp,
  input logic             cs_n,
  input logic             we_n,
  input logic             oe_n,
  input logic             data_oe,
  input logic [7:0]       data_out,
  input logic             wr_act,
  input logic [REC_W-1:0] rec
);

  p_read_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> $past(!cs_n && !oe_n && we_n));

  p_we_override_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !data_oe);

  p_wp_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> (!data_oe && data_out == 8'h00));

  p_wp_noopen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wp |=> !wr_act);

  p_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec != '0) |=> !data_oe);

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == 8'h00);

endmodule

bind nvbyte_sram nvbyte_sram_chk #(.REC_W(REC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wp(wp), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
  .data_oe(data_oe), .data_out(data_out), .wr_act(wr_act), .rec(rec)
);

// File: tb/nvbyte_sram_tb.sv
module nvbyte_sram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int REC = 3;

  logic clk = 0, rst_n = 0, wp = 0, cs_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] data_in = '0, data_out;
  logic data_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvbyte_sram #(.ADDR_W(AW), .DEPTH(256), .REC_CLKS(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp(wp), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe));

  localparam logic [26:0] VEC [6] = '{
    {19'h00000, 8'h5A}, {19'h00001, 8'hA5}, {19'h0007F, 8'h00},
    {19'h00080, 8'hFF}, {19'h000FE, 8'h3C}, {19'h000FF, 8'hC3}};

  task automatic step(); @(posedge clk); #1; endtask

  task automatic idle(); cs_n = 1; we_n = 1; oe_n = 1; endtask

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual oe/data=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    addr = a; data_in = d; cs_n = 0; we_n = 0; oe_n = 1;
    step(); step();
    idle(); step();
    repeat (REC + 1) step();
  endtask

  task automatic rd(string req, logic [AW-1:0] a, logic [7:0] exp);
    addr = a; cs_n = 0; oe_n = 0; we_n = 1;
    step();
    check(req, {data_oe, data_out}, {1'b1, exp});
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step();
    check("R9 in reset", {data_oe, data_out}, 9'h000);
    step(); rst_n = 1; step();
    check("R9 after reset", {data_oe, data_out}, 9'h000);

    foreach (VEC[i]) wr(VEC[i][26:8], VEC[i][7:0]);
    foreach (VEC[i]) rd("R1 vector read", VEC[i][26:8], VEC[i][7:0]);

    // R2: upper bits alias
    wr(19'h40105, 8'h77);
    rd("R2 alias", 19'h00005, 8'h77);

    // R3/R4: cs_n first, we_n last; data changes inside window; close by we_n
    addr = 19'h10; data_in = 8'h11; cs_n = 0; step();
    we_n = 0; step();
    data_in = 8'h22; step();
    addr = 19'h11; data_in = 8'h33; we_n = 1; step();
    idle(); repeat (REC + 1) step();
    rd("R4 last window data", 19'h10, 8'h22);

    // R3/R4: we_n first, cs_n last; close by cs_n while we_n low
    addr = 19'h12; data_in = 8'h44; we_n = 0; step();
    cs_n = 0; step();
    cs_n = 1; step();
    we_n = 1; repeat (REC + 1) step();
    rd("R3 order independent", 19'h12, 8'h44);

    // R10: idle output
    idle(); step();
    check("R10 idle zero", {data_oe, data_out}, 9'h000);

    // R5: we_n falls during active read
    addr = 19'h12; cs_n = 0; oe_n = 0; we_n = 1; step();
    check("R5 read active", {data_oe, data_out}, {1'b1, 8'h44});
    data_in = 8'h55; we_n = 0; step();
    check("R5 we override", {data_oe, data_out}, 9'h000);
    idle(); step(); repeat (REC + 1) step();
    rd("R5 write landed", 19'h12, 8'h55);

    // R6: wp releases bus immediately
    addr = 19'h12; cs_n = 0; oe_n = 0; we_n = 1; step();
    wp = 1; #1;
    check("R6 wp release", {data_oe, data_out}, 9'h000);
    oe_n = 1; data_in = 8'hEE; we_n = 0; step(); step();
    we_n = 1; cs_n = 1; step();
    wp = 0; step(); repeat (REC + 1) step();
    rd("R6 no write under wp", 19'h12, 8'h55);

    // R7: wp rises at same edge as window close
    addr = 19'h12; data_in = 8'h99; cs_n = 0; we_n = 0; step(); step();
    wp = 1; we_n = 1; step();
    wp = 0; idle(); step(); repeat (REC + 1) step();
    rd("R7 abort same edge", 19'h12, 8'h55);

    // R8: recovery after commit, read requested at commit edge
    addr = 19'h20; data_in = 8'h66; cs_n = 0; we_n = 0; step(); step();
    we_n = 1; oe_n = 0; step();
    check("R8 commit edge", {data_oe, data_out}, 9'h000);
    for (int k = 1; k < REC; k++) begin
      step(); check("R8 recovery", {data_oe, data_out}, 9'h000);
    end
    step(); check("R8 recovery last", {data_oe, data_out}, 9'h000);
    step(); check("R8 after recovery", {data_oe, data_out}, {1'b1, 8'h66});

    // R8: write attempt during recovery is refused and restarts count
    idle(); addr = 19'h21; data_in = 8'h01; cs_n = 0; we_n = 0; step(); step();
    we_n = 1; step();
    addr = 19'h21; data_in = 8'hBB; we_n = 0; step();
    we_n = 1; oe_n = 0; step();
    check("R8 restart blocks read", {data_oe, data_out}, 9'h000);
    idle(); repeat (REC + 1) step();
    rd("R8 refused write", 19'h21, 8'h01);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule